// File: doc/BRIEF.md
# Raster Timing Generator with Two Wrapping Overlay Boxes

This block produces the scan timing for a progressive display from a pixel clock. It supplies horizontal and vertical sync, an active-video flag, a 24-bit colour per pixel and a read address for a quarter-scale image memory. A horizontal counter steps once per pixel clock. A vertical counter steps once per line. Each line and each frame runs through the same four phases in this order: active video, front porch, sync pulse, back porch. Every phase length is a parameter. The defaults give a 1280x720 mode with 1280/110/40/220 pixels horizontally and 720/5/5/20 lines vertically. A 1920x1080 mode (1920/88/44/148 and 1080/4/5/36, pixel clock 148.5 MHz) is selected only by overriding the parameters.

The background is a set of colour bars taken from three bits of the horizontal counter. Two rectangles of a fixed size are drawn over it. The top-left corner and colour of each rectangle come from input ports. A rectangle that runs past the right or bottom edge of the active area continues from the left or top edge. The image address scales the picture by four in both directions: it is built from both counters shifted right by two and laid out row-major.

Top module: `vid_raster`

## Requirements
- R1: After reset both counters are zero, which is the first active pixel of the first line. The horizontal counter runs 0..H_TOT-1 and then returns to 0. The vertical counter advances only when the horizontal counter wraps, and it returns to 0 after V_TOT lines. Each line and frame runs in the phase order active, front porch, sync, back porch.
- R2: `hsync` is high exactly while the horizontal count lies in [H_ACT+H_FP, H_ACT+H_FP+H_SYNC), and it does so on every line.
- R3: `vsync` is high for every pixel of the lines whose vertical count lies in [V_ACT+V_FP, V_ACT+V_FP+V_SYNC).
- R4: `active` is high exactly when the horizontal count is below H_ACT and the vertical count is below V_ACT.
- R5: On an active pixel covered by no box, `rgb[23:16]` is 8'hFF when horizontal count bit BAR_BIT+2 is set and 0 otherwise. `rgb[15:8]` follows bit BAR_BIT+1 and `rgb[7:0]` follows bit BAR_BIT in the same way.
- R6: `rgb` is zero whenever `active` is low.
- R7: A box with corner (x,y) covers an active pixel (h,v) when (h-x) mod H_ACT < BOX_W and (v-y) mod V_ACT < BOX_H. A covered pixel shows that box's colour, so a box wraps across the right and bottom edges.
- R8: Where both boxes cover a pixel, box 1's colour is shown.
- R9: `img_addr` equals (v>>2)*(H_ACT/4) + (h>>2) on active pixels and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| box1_x | input | CW | Box 1 left column, below H_ACT |
| box1_y | input | CW | Box 1 top line, below V_ACT |
| box1_rgb | input | 24 | Box 1 colour |
| box2_x | input | CW | Box 2 left column, below H_ACT |
| box2_y | input | CW | Box 2 top line, below V_ACT |
| box2_rgb | input | 24 | Box 2 colour |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | Active-video flag |
| rgb | output | 24 | Pixel colour {R,G,B} |
| img_addr | output | AW | Quarter-scale image address |

## Verification
The bench puts boxes on the last columns and lines so that they split across both edges. A design that does not wrap would draw only the part of the box that fits, or draw nothing where the box reappears at column 0 or line 0. Overlapping boxes with different colours expose a reversed priority. A box at the far corner checks the modulo arithmetic at its extremes. Comparing every pixel of whole frames catches a sync pulse shifted by one count, a vsync that is not aligned to whole lines, colour leaking into the blanking interval, and an image address that wraps at the wrong row width.

// File: rtl/vid_raster.sv
module vid_raster #(
  parameter int H_ACT   = 1280,
  parameter int H_FP    = 110,
  parameter int H_SYNC  = 40,
  parameter int H_BP    = 220,
  parameter int V_ACT   = 720,
  parameter int V_FP    = 5,
  parameter int V_SYNC  = 5,
  parameter int V_BP    = 20,
  parameter int BOX_W   = 128,
  parameter int BOX_H   = 96,
  parameter int BAR_BIT = 6,
  parameter int CW      = 12,
  localparam int AW     = $clog2((H_ACT / 4) * (V_ACT / 4))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] box1_x,
  input  logic [CW-1:0] box1_y,
  input  logic [23:0]   box1_rgb,
  input  logic [CW-1:0] box2_x,
  input  logic [CW-1:0] box2_y,
  input  logic [23:0]   box2_rgb,
  output logic          hsync,
  output logic          vsync,
  output logic          active,
  output logic [23:0]   rgb,
  output logic [AW-1:0] img_addr
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam logic [CW-1:0] H_LAST = CW'(H_TOT - 1);
  localparam logic [CW-1:0] V_LAST = CW'(V_TOT - 1);
  localparam logic [CW-1:0] H_ACT_C = CW'(H_ACT);
  localparam logic [CW-1:0] V_ACT_C = CW'(V_ACT);
  localparam logic [CW-1:0] HS_BEG = CW'(H_ACT + H_FP);
  localparam logic [CW-1:0] HS_END = CW'(H_ACT + H_FP + H_SYNC);
  localparam logic [CW-1:0] VS_BEG = CW'(V_ACT + V_FP);
  localparam logic [CW-1:0] VS_END = CW'(V_ACT + V_FP + V_SYNC);
  localparam logic [CW:0] HA = (CW+1)'(H_ACT);
  localparam logic [CW:0] VA = (CW+1)'(V_ACT);
  localparam logic [CW:0] BW = (CW+1)'(BOX_W);
  localparam logic [CW:0] BH = (CW+1)'(BOX_H);
  localparam int QW = H_ACT / 4;

  logic [CW-1:0] hc, vc;
  logic hit1, hit2;
  logic [23:0] bars;

  function automatic logic in_span(input logic [CW-1:0] c, input logic [CW-1:0] o,
                                   input logic [CW:0] span, input logic [CW:0] len);
    logic [CW:0] d;
    d = (c >= o) ? {1'b0, c - o} : {1'b0, c} + span - {1'b0, o};
    return d < len;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (hc == H_LAST) begin
      hc <= '0;
      vc <= (vc == V_LAST) ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  assign active = (hc < H_ACT_C) && (vc < V_ACT_C);
  assign hsync  = (hc >= HS_BEG) && (hc < HS_END);
  assign vsync  = (vc >= VS_BEG) && (vc < VS_END);

  assign hit1 = in_span(hc, box1_x, HA, BW) && in_span(vc, box1_y, VA, BH);
  assign hit2 = in_span(hc, box2_x, HA, BW) && in_span(vc, box2_y, VA, BH);
  assign bars = {{8{hc[BAR_BIT+2]}}, {8{hc[BAR_BIT+1]}}, {8{hc[BAR_BIT]}}};

  assign rgb = !active ? 24'h0 : hit1 ? box1_rgb : hit2 ? box2_rgb : bars;
  assign img_addr = active ? AW'(32'(vc >> 2) * 32'(QW) + 32'(hc >> 2)) : '0;

  AST_HC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hc <= H_LAST); // R1
  AST_HC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hc) == H_LAST |-> hc == '0); // R1
  AST_VC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vc) |-> hc == '0); // R1
  AST_HSYNC_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> hc == HS_END); // R2
  AST_VSYNC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |-> hc == '0); // R3
  AST_RGB_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> rgb == 24'h0); // R6
  AST_ADDR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> img_addr == '0); // R9
endmodule

// File: tb/vid_raster_test.sv
module vid_raster_test;
  localparam int H_ACT = 24, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_ACT = 16, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int BOX_W = 5, BOX_H = 4, BAR_BIT = 1, CW = 8;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int AW = $clog2((H_ACT / 4) * (V_ACT / 4));
  localparam int FRAMES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] b1x = '0, b1y = '0, b2x = '0, b2y = '0;
  logic [23:0] b1c = '0, b2c = '0;
  logic hsync, vsync, active;
  logic [23:0] rgb;
  logic [AW-1:0] img_addr;
  int mh = 0, mv = 0;
  int vectors = 0, errors = 0;
  int fr = 0;
  bit done = 1'b0;

  vid_raster #(.H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .BOX_W(BOX_W), .BOX_H(BOX_H), .BAR_BIT(BAR_BIT), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .box1_x(b1x), .box1_y(b1y), .box1_rgb(b1c),
    .box2_x(b2x), .box2_y(b2y), .box2_rgb(b2c),
    .hsync(hsync), .vsync(vsync), .active(active), .rgb(rgb), .img_addr(img_addr));

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh <= 0; mv <= 0;
    end else if (mh == H_TOT - 1) begin
      mh <= 0;
      mv <= (mv == V_TOT - 1) ? 0 : mv + 1;
    end else begin
      mh <= mh + 1;
    end
  end

  function automatic bit covers(int c, int o, int span, int len);
    int d;
    d = (c >= o) ? c - o : c + span - o;
    return d < len;
  endfunction

  function automatic bit in_box(int h, int v, int x, int y);
    return covers(h, x, H_ACT, BOX_W) && covers(v, y, V_ACT, BOX_H);
  endfunction

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at h=%0d v=%0d: got %0h expected %0h", req, mh, mv, act, exp);
    end
  endtask

  task automatic check_all();
    bit ea, k1, k2;
    logic [23:0] er;
    string rq;
    ea = (mh < H_ACT) && (mv < V_ACT);
    k1 = in_box(mh, mv, b1x, b1y);
    k2 = in_box(mh, mv, b2x, b2y);
    check("R1 R4 active", active, ea);
    check("R2 hsync", hsync, (mh >= H_ACT + H_FP) && (mh < H_ACT + H_FP + H_SYNC));
    check("R3 vsync", vsync, (mv >= V_ACT + V_FP) && (mv < V_ACT + V_FP + V_SYNC));
    if (!ea) begin
      er = '0; rq = "R6 blank rgb";
    end else if (k1) begin
      er = b1c; rq = k2 ? "R8 box priority" : "R7 box1";
    end else if (k2) begin
      er = b2c; rq = "R7 box2";
    end else begin
      er = {{8{mh[BAR_BIT+2]}}, {8{mh[BAR_BIT+1]}}, {8{mh[BAR_BIT]}}};
      rq = "R5 bars";
    end
    check(rq, rgb, er);
    check("R9 img_addr", img_addr, ea ? (mv / 4) * (H_ACT / 4) + mh / 4 : 0);
  endtask

  task automatic set_boxes(int f);
    case (f)
      0: begin b1x = 22; b1y = 14; b2x = 0; b2y = 8; end
      1: begin b1x = 3; b1y = 3; b2x = 5; b2y = 4; end
      2: begin b1x = 0; b1y = 0; b2x = H_ACT - 1; b2y = V_ACT - 1; end
      3: begin b1x = 10; b1y = 6; b2x = 10; b2y = 6; end
      default: begin
        b1x = CW'($urandom % H_ACT); b1y = CW'($urandom % V_ACT);
        b2x = CW'($urandom % H_ACT); b2y = CW'($urandom % V_ACT);
      end
    endcase
    b1c = 24'($urandom); b2c = 24'($urandom);
    if (b1c == b2c) b2c = ~b1c;
  endtask

  initial begin
    void'($urandom(1234));
    set_boxes(0);
    repeat (4) begin
      @(negedge clk); #1;
      check_all();
    end
    rst_n = 1'b1;
    for (int i = 0; i < FRAMES * H_TOT * V_TOT; i++) begin
      @(negedge clk);
      if (mh == 0 && mv == 0) begin
        fr++;
        set_boxes(fr);
      end
      #1;
      check_all();
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule